// File: doc/BRIEF.md
# Carry-Completion Detection Adder

This block adds two WIDTH-bit unsigned operands and a carry-in. Each bit position keeps its carry as a pair of rails. One rail says the carry is a one, the other says it is a zero, and the pair at rest says the carry is still unknown. The design is clocked. A one-cycle start pulse captures the operands and puts every position above the bottom into the unknown code. On each clock after that, every position works out its rails again from its own operand bits and the rails the position below held on the previous cycle. Knowledge therefore moves up a propagate run by one position per clock. Positions that generate or kill a carry settle on the first clock.

A completion flag rises on the clock where every rail pair first holds a known carry. The sum, the carry-out and a count of the clocks the resolution took are registered on that same edge. The latency is not fixed. It follows the longest carry chain of the operands actually presented. A start pulse that arrives during a computation abandons it and begins again with the operands presented alongside that pulse.

The controller has three states. ST_IDLE is the state after reset. ST_RUN means the rails are resolving. ST_DONE means the results are held. The named transitions are:
- start (ST_IDLE or ST_DONE to ST_RUN, on a start pulse)
- restart (ST_RUN to ST_RUN, on a start pulse while resolving)
- settle (ST_RUN to ST_DONE, when every next rail pair is known and no start pulse is present)
- wait (ST_RUN stays in ST_RUN while some rail is still unknown)

Top module: `ccd_adder`

## Requirements
- R1: A rail pair is written {zero-rail, one-rail}. The code 2'b00 means the carry is unknown, 2'b01 means the carry is known to be 1, and 2'b10 means the carry is known to be 0. The code 2'b11 is never held.
- R2: The clock edge that samples start_i high loads x_i, y_i and cin_i. It sets the bottom rail pair from cin_i and sets every higher pair to unknown. done_o is low after that edge.
- R3: On each resolving clock, the pair above position i becomes known-1 when x[i] and y[i] are both 1, or when they differ and the pair at i was known-1. It becomes known-0 when both bits are 0, or when they differ and the pair at i was known-0. Otherwise it stays unknown.
- R4: Position j resolves at time t(j). The bottom position has t(0) = 0. For j from 1 to WIDTH, t(j) = t(j-1) + 1 when x[j-1] differs from y[j-1], and t(j) = 1 otherwise. done_o first reads high exactly T = max t(j) clock edges after the start edge, and cycles_o then equals T.
- R5: While done_o is high, {cout_o, sum_o} equals x + y + cin taken over WIDTH+1 bits.
- R6: While done_o is low, sum_o, cout_o and cycles_o are all zero.
- R7: A start pulse during resolution abandons the running addition. The result and the timing then follow the new operands, counted from the new start edge.
- R8: Once high, done_o, sum_o, cout_o and cycles_o hold until the next start pulse.
- R9: After reset, done_o, sum_o, cout_o and cycles_o are zero.
- R10: Operands in which no position propagates settle in 1 clock. A propagate run covering every position from the carry-in settles in WIDTH clocks, which is the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that loads the operands and begins resolution |
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in |
| done_o | output | 1 | High once every carry is known |
| sum_o | output | WIDTH | Sum, valid while done_o is high |
| cout_o | output | 1 | Carry-out, valid while done_o is high |
| cycles_o | output | $clog2(WIDTH+1) | Clocks the resolution took |

## Verification
After the edge that samples start_i, the bench waits half a period and confirms that done_o is low and the outputs are zero. From then on it counts each following edge, sampling at the falling edge, until done_o rises. That count must equal T, which the bench computes on its own from the chain rule in R4. The sum, carry-out and cycles_o are read in the same half-cycle, because they are registered on the same edge as done_o. The hold and restart cases are sampled at fixed edge offsets from their own start pulses.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    // rail pair layout: bit 1 = zero-rail, bit 0 = one-rail
    localparam logic [1:0] RAIL_UNK  = 2'b00;
    localparam logic [1:0] RAIL_ONE  = 2'b01;
    localparam logic [1:0] RAIL_ZERO = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/ccd_rail_cell.sv
module ccd_rail_cell (
    input  logic       x_bit,
    input  logic       y_bit,
    input  logic [1:0] rail_lo,
    output logic [1:0] rail_hi
);

    logic prop;
    logic gen;
    logic kill;

    always_comb begin
        prop       = x_bit ^ y_bit;
        gen        = x_bit & y_bit;
        kill       = ~x_bit & ~y_bit;
        rail_hi[0] = gen  | (prop & rail_lo[0]);
        rail_hi[1] = kill | (prop & rail_lo[1]);
    end

endmodule

// File: rtl/ccd_rail_chain.sv
module ccd_rail_chain
    import ccd_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             cin_in,
    output logic             all_known_nxt,
    output logic [WIDTH-1:0] sum_nxt,
    output logic             cout_nxt
);

    localparam int NPOS = WIDTH + 1;

    logic [WIDTH-1:0] x_q;
    logic [WIDTH-1:0] y_q;
    logic [1:0]       rail_q   [NPOS];
    logic [1:0]       rail_nxt [NPOS];
    logic [NPOS-1:0]  known_vec;

    assign rail_nxt[0] = rail_q[0];

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        ccd_rail_cell u_cell (
            .x_bit   (x_q[i]),
            .y_bit   (y_q[i]),
            .rail_lo (rail_q[i]),
            .rail_hi (rail_nxt[i+1])
        );
        assign sum_nxt[i] = x_q[i] ^ y_q[i] ^ rail_nxt[i][0];
    end

    for (genvar j = 0; j < NPOS; j++) begin : g_known
        assign known_vec[j] = rail_nxt[j][0] | rail_nxt[j][1];
    end

    assign all_known_nxt = &known_vec;
    assign cout_nxt      = rail_nxt[WIDTH][0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
            for (int p = 0; p < NPOS; p++) rail_q[p] <= RAIL_UNK;
        end else if (load) begin
            x_q       <= x_in;
            y_q       <= y_in;
            rail_q[0] <= cin_in ? RAIL_ONE : RAIL_ZERO;
            for (int p = 1; p < NPOS; p++) rail_q[p] <= RAIL_UNK;
        end else if (step) begin
            for (int p = 1; p < NPOS; p++) rail_q[p] <= rail_nxt[p];
        end
    end

    // R2: bottom pair follows the captured carry-in
    a_r2_bottom_rail: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> rail_q[0] == ($past(cin_in) ? RAIL_ONE : RAIL_ZERO));

    for (genvar k = 0; k < NPOS; k++) begin : g_chk
        // R1: the illegal code never appears
        a_r1_rail_legal: assert property (@(posedge clk) disable iff (!rst_n)
            rail_q[k] != 2'b11);
        // R3: a resolved carry never changes until the next load
        a_r3_rail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (!load && rail_q[k] != RAIL_UNK) |=> rail_q[k] == $past(rail_q[k]));
        if (k > 0) begin : g_upper
            // R2: upper pairs start unknown
            a_r2_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
                load |=> rail_q[k] == RAIL_UNK);
        end
    end

endmodule

// File: rtl/ccd_ctrl.sv
module ccd_ctrl
    import ccd_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             all_known_nxt,
    input  logic [WIDTH-1:0] sum_nxt,
    input  logic             cout_nxt,
    output logic             step,
    output logic             done_o,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic [CNT_W-1:0] cycles_o
);

    ctl_state_e       state_q;
    ctl_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             finish;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN: begin
                if (start)              state_d = ST_RUN;
                else if (all_known_nxt) state_d = ST_DONE;
                else                    state_d = ST_RUN;
            end
            ST_DONE: if (start) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    assign step   = (state_q == ST_RUN) && !start;
    assign finish = step && all_known_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            sum_o    <= '0;
            cout_o   <= 1'b0;
            cycles_o <= '0;
            cnt_q    <= '0;
        end else if (start) begin
            done_o   <= 1'b0;
            sum_o    <= '0;
            cout_o   <= 1'b0;
            cycles_o <= '0;
            cnt_q    <= '0;
        end else begin
            if (step) cnt_q <= cnt_q + CNT_W'(1);
            if (finish) begin
                done_o   <= 1'b1;
                sum_o    <= sum_nxt;
                cout_o   <= cout_nxt;
                cycles_o <= cnt_q + CNT_W'(1);
            end
        end
    end

    a_r6_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (sum_o == '0 && !cout_o && cycles_o == '0));
    a_r2_start_drops_done: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done_o);
    a_r4_cycles_range: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cycles_o >= CNT_W'(1) && cycles_o <= CNT_W'(WIDTH)));
    a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start) |=> (done_o && $stable(sum_o) && $stable(cout_o) && $stable(cycles_o)));
    a_r4_done_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(state_q) == ST_RUN);

endmodule

// File: rtl/ccd_adder.sv
module ccd_adder #(
    parameter int WIDTH = 16,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic             done_o,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic [CNT_W-1:0] cycles_o
);

    logic             step;
    logic             all_known_nxt;
    logic [WIDTH-1:0] sum_nxt;
    logic             cout_nxt;

    ccd_rail_chain #(.WIDTH(WIDTH)) u_chain (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (start_i),
        .step          (step),
        .x_in          (x_i),
        .y_in          (y_i),
        .cin_in        (cin_i),
        .all_known_nxt (all_known_nxt),
        .sum_nxt       (sum_nxt),
        .cout_nxt      (cout_nxt)
    );

    ccd_ctrl #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start_i),
        .all_known_nxt (all_known_nxt),
        .sum_nxt       (sum_nxt),
        .cout_nxt      (cout_nxt),
        .step          (step),
        .done_o        (done_o),
        .sum_o         (sum_o),
        .cout_o        (cout_o),
        .cycles_o      (cycles_o)
    );

endmodule

// File: tb/ccd_adder_bench.sv
module ccd_adder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int CW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [W-1:0]  x_i = '0;
    logic [W-1:0]  y_i = '0;
    logic          cin_i = 1'b0;
    logic          done_o;
    logic [W-1:0]  sum_o;
    logic          cout_o;
    logic [CW-1:0] cycles_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccd_adder #(.WIDTH(W)) u_ccd_adder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .x_i(x_i), .y_i(y_i),
        .cin_i(cin_i), .done_o(done_o), .sum_o(sum_o), .cout_o(cout_o),
        .cycles_o(cycles_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ref_t(input logic [W-1:0] a, input logic [W-1:0] b);
        int t = 0;
        int m = 0;
        for (int i = 0; i < W; i++) begin
            if (a[i] ^ b[i]) t = t + 1;
            else             t = 1;
            if (t > m) m = t;
        end
        return m;
    endfunction

    // pulse start at a falling edge; returns at the falling edge after the start edge
    task automatic pulse(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
        @(negedge clk);
        x_i = a; y_i = b; cin_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
        int n = 0;
        int texp = ref_t(a, b);
        logic [W:0] full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        pulse(a, b, c);
        chk(!done_o, "R2 done low after start", done_o, 0);
        chk(sum_o == '0 && !cout_o && cycles_o == '0, "R6 outputs zero while busy",
            {cout_o, sum_o}, 0);
        while (!done_o && n < 3*W) begin
            @(negedge clk);
            n++;
            if (!done_o) chk(sum_o == '0 && cycles_o == '0, "R6 zero while resolving", sum_o, 0);
        end
        chk(n == texp, "R4 done edge count", n, texp);
        chk(int'(cycles_o) == texp, "R4 cycles_o", cycles_o, texp);
        chk({cout_o, sum_o} == full, "R5 sum and carry-out", {cout_o, sum_o}, full);
    endtask

    task automatic t_reset;
        chk(!done_o && sum_o == '0 && !cout_o && cycles_o == '0, "R9 reset state",
            {done_o, cout_o, sum_o}, 0);
    endtask

    task automatic t_no_propagate;
        run_add('0, '0, 1'b0);
        chk(cycles_o == CW'(1), "R10 all kill in one clock", cycles_o, 1);
        run_add('1, '1, 1'b1);
        chk(cycles_o == CW'(1), "R10 all generate in one clock", cycles_o, 1);
        run_add(16'hAAAA, 16'hAAAA, 1'b0);
    endtask

    task automatic t_full_propagate;
        run_add(16'hFFFF, 16'h0000, 1'b1);
        chk(cycles_o == CW'(W) && sum_o == '0 && cout_o, "R10 R3 carry ripples full width",
            {cout_o, cycles_o}, {1'b1, CW'(W)});
        run_add(16'h0000, 16'hFFFF, 1'b0);
        chk(sum_o == 16'hFFFF && !cout_o, "R3 zero ripples full width", sum_o, 16'hFFFF);
        run_add(16'h0001, 16'hFFFF, 1'b0);
    endtask

    task automatic t_mixed;
        logic [W-1:0] a = 16'h1D2B;
        logic [W-1:0] b = 16'h7E41;
        run_add(16'h1234, 16'h4321, 1'b0);
        run_add(16'h00F0, 16'h0F10, 1'b1);
        for (int i = 0; i < 12; i++) begin
            a = a * 16'd25173 + 16'd13849;
            b = b * 16'd20077 + 16'd1237;
            run_add(a, b ^ (a >> (i % 5)), 1'(i & 1));
        end
    endtask

    task automatic t_hold;
        run_add(16'h0F0F, 16'h00F1, 1'b0);
        repeat (4) @(negedge clk);
        chk(done_o && sum_o == 16'h1000 && cycles_o == CW'(ref_t(16'h0F0F, 16'h00F1)),
            "R8 result held", sum_o, 16'h1000);
        pulse(16'h0001, 16'h0001, 1'b0);
        chk(!done_o && sum_o == '0, "R8 start while done clears", {done_o, sum_o}, 0);
        @(negedge clk);
        chk(done_o && sum_o == 16'h0002 && cycles_o == CW'(1), "R8 next result", sum_o, 2);
    endtask

    task automatic t_abort;
        pulse(16'hFFFF, 16'h0000, 1'b1);
        @(negedge clk);
        @(negedge clk);
        chk(!done_o, "R7 long add still resolving", done_o, 0);
        run_add(16'h0003, 16'h0005, 1'b0);
        chk(sum_o == 16'h0008 && cycles_o == CW'(ref_t(16'h0003, 16'h0005)),
            "R7 restart uses new operands", sum_o, 8);
        pulse(16'hFFFF, 16'h0000, 1'b1);
        pulse(16'h7FFF, 16'h0000, 1'b1);
        repeat (W - 2) @(negedge clk);
        chk(!done_o, "R7 timing counts from new start early", done_o, 0);
        @(negedge clk);
        chk(done_o && cycles_o == CW'(W-1) && sum_o == 16'h8000,
            "R7 timing counts from new start", cycles_o, W-1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_propagate();
        t_full_propagate();
        t_mixed();
        t_hold();
        t_abort();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule